// File: doc/BRIEF.md
# Single-Frame Packet Port

The block is a host-programmed network port that holds exactly one received frame and one outgoing frame, each in its own byte buffer of up to 1514 bytes. A host reaches it through a small register window: 6-bit address, separate read and write strobes, and 32-bit data. Through that window the host reads a pair of identification words, a busy flag and the two byte counts, and it controls the interrupt flags. Two one-byte data windows give access to the buffers.

On the network side, received frames enter on a byte stream with valid, data, last and a ready output. Outgoing frames leave on a byte stream with valid, data and last, and the consumer supplies ready. One busy flag acts as the receive gate. Any completed transfer sets busy, and an acknowledge written to the interrupt control register reopens the gate. Writing the test bit to that register soft-resets the whole port. The single interrupt line stays high while any interrupt flag is set.

A host read takes effect on the clock edge that samples `rd_i`. The returned word appears on `rdata_o` after that edge and holds until the next read. Any side effect of the read lands on the same edge.

Top module: `frame_port`

## Requirements
- R1: The port decodes offsets as follows. 0x00 reads 0x4D495053 and 0x04 reads 0x4E455430. 0x18, 0x20 and every unmapped offset read 0. 0x08 reads busy in bit 0, 0x0C reads the receive count and 0x10 reads the transmit count.
- R2: After reset, busy reads 1 and both counts and interrupt control read 0. `irq_o`, `rx_ready_o` and `tx_valid_o` are all low.
- R3: Interrupt control (offset 0x14) has three flags: transmit done in bit 0, receive done in bit 1 and test in bit 31. `irq_o` is high exactly while at least one of them is set.
- R4: A write to 0x14 is resolved by priority. If bit 0 is set, only transmit done is cleared. Otherwise, if bit 1 is set, only receive done is cleared. Otherwise, if bit 31 is set, a soft reset is performed and the test flag is set. A zero write changes no flag. After any such write, busy becomes 1 if a flag remains and 0 if none does.
- R5: A read of 0x14 returns the flags as they were before the read, and it clears the test flag.
- R6: A write to 0x10 stores the value when it is at most 1514 and stores 0 otherwise. The write also rewinds the transmit fill pointer.
- R7: Each write to 0x20 stores bits 7:0 at the fill pointer and advances the pointer. When the pointer reaches the count, the frame is sent: the count returns to 0, transmit done is set and busy is set. A data write is ignored when the count is 0 or while a frame is still streaming out.
- R8: The transmit stream sends the frame bytes in order from offset 0 and marks the final byte with `tx_last_o`. While `tx_ready_i` is low, it holds the current byte steady.
- R9: `rx_ready_o` opens for a new frame only when busy is 0 and the receive count is below 1514. Accepting the first byte of a frame sets busy.
- R10: When the last byte is accepted, the receive count becomes the number of bytes stored, the read pointer rewinds and receive done is set. Bytes beyond 1514 are accepted but dropped.
- R11: A read of 0x1C with a nonzero count returns the next byte, advances the pointer and decrements the count. With a count of 0 it returns 0 and changes nothing.
- R12: Writes to read-only offsets (0x00, 0x08, 0x0C, 0x18, 0x1C) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register offset |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data, registered |
| irq_o | output | 1 | Level interrupt |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Final byte of received frame |
| rx_ready_o | output | 1 | Port accepts receive byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Final byte of transmitted frame |
| tx_ready_i | input | 1 | Consumer accepts transmit byte |

## Verification
A register sweep after reset separates correct offset decode from aliasing or wrongly mapped words. The receive side is driven with three patterns, each exposing a different fault:
- a short frame, which checks byte order and count bookkeeping;
- a frame offered while busy, which checks the gate;
- an oversize frame of 1520 bytes, which tells truncation apart from wrap-around and shows the count-full gate.

The transmit side sends two frames. The first waits under held-off ready, which tests that the output is held. A stray data write lands during the drain; if that write were wrongly accepted, it would change the bytes of the second frame. Writes to interrupt control with several bits set together separate the three priority branches.

// File: rtl/frame_port_pkg.sv
package frame_port_pkg;
  localparam logic [5:0] OFS_ID0   = 6'h00;
  localparam logic [5:0] OFS_ID1   = 6'h04;
  localparam logic [5:0] OFS_BUSY  = 6'h08;
  localparam logic [5:0] OFS_RXCNT = 6'h0C;
  localparam logic [5:0] OFS_TXCNT = 6'h10;
  localparam logic [5:0] OFS_ICTL  = 6'h14;
  localparam logic [5:0] OFS_IINFO = 6'h18;
  localparam logic [5:0] OFS_RXDAT = 6'h1C;
  localparam logic [5:0] OFS_TXDAT = 6'h20;

  localparam logic [31:0] ID_WORD0 = 32'h4D49_5053;
  localparam logic [31:0] ID_WORD1 = 32'h4E45_5430;

  typedef struct packed {
    logic test;
    logic rx_done;
    logic tx_done;
  } ictl_t;

  function automatic logic [31:0] ictl_word(ictl_t c);
    return {c.test, 29'b0, c.rx_done, c.tx_done};
  endfunction
endpackage

// File: rtl/frame_byte_ram.sv
module frame_byte_ram #(
  parameter int DEPTH = 1514,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && int'(waddr_i) < DEPTH) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = (int'(raddr_i) < DEPTH) ? mem[raddr_i] : 8'h00;
endmodule

// File: rtl/frame_rx_fill.sv
module frame_rx_fill #(
  parameter int FRAME_MAX = 1514,
  parameter int CW        = $clog2(FRAME_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_clr_i,
  input  logic          open_i,
  input  logic          rx_valid_i,
  input  logic          rx_last_i,
  output logic          rx_ready_o,
  output logic          store_o,
  output logic [CW-1:0] waddr_o,
  output logic          start_o,
  output logic          done_o,
  output logic [CW-1:0] len_o
);
  logic          filling_q;
  logic [CW-1:0] cnt_q;
  logic          accept;

  assign rx_ready_o = filling_q | open_i;
  assign accept     = rx_valid_i & rx_ready_o;
  assign store_o    = accept & (cnt_q < CW'(FRAME_MAX));
  assign waddr_o    = cnt_q;
  assign start_o    = accept & ~filling_q;
  assign done_o     = accept & rx_last_i;
  assign len_o      = cnt_q + CW'(store_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filling_q <= 1'b0;
      cnt_q     <= '0;
    end else if (soft_clr_i) begin
      filling_q <= 1'b0;
      cnt_q     <= '0;
    end else if (accept) begin
      if (rx_last_i) begin
        filling_q <= 1'b0;
        cnt_q     <= '0;
      end else begin
        filling_q <= 1'b1;
        cnt_q     <= len_o;
      end
    end
  end

  // R10: a finished frame never reports zero bytes or more than the buffer holds
  a_r10_len_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (len_o != '0) && (len_o <= CW'(FRAME_MAX)));
endmodule

// File: rtl/frame_tx_drain.sv
module frame_tx_drain #(
  parameter int CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_clr_i,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  input  logic          tx_ready_i,
  output logic          active_o,
  output logic [CW-1:0] raddr_o,
  output logic          tx_valid_o,
  output logic          tx_last_o
);
  logic          active_q;
  logic [CW-1:0] idx_q;
  logic [CW-1:0] len_q;

  assign active_o   = active_q;
  assign raddr_o    = idx_q;
  assign tx_valid_o = active_q;
  assign tx_last_o  = active_q && (idx_q == len_q - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
    end else if (soft_clr_i) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      len_q    <= len_i;
    end else if (active_q && tx_ready_i) begin
      if (tx_last_o) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + CW'(1);
      end
    end
  end

  // R8: a stalled byte stays presented unchanged
  a_r8_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !soft_clr_i) |=> tx_valid_o && $stable(raddr_o));
endmodule

// File: rtl/frame_port.sv
module frame_port
  import frame_port_pkg::*;
#(
  parameter int FRAME_MAX = 1514,
  localparam int CW       = $clog2(FRAME_MAX + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [5:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_last_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i
);
  logic          busy_q, busy_d;
  logic [CW-1:0] rx_cnt_q, rx_cnt_d, rx_rd_q, rx_rd_d;
  logic [CW-1:0] tx_cnt_q, tx_cnt_d, tx_wr_q, tx_wr_d;
  ictl_t         ictl_q, ictl_d;
  logic [31:0]   rdata_q, rdata_d;

  logic          wr_ictl, rd_ictl, soft_rst, tx_take, tx_send, rx_pop, rx_open;
  logic          fill_store, fill_start, fill_done;
  logic [CW-1:0] fill_waddr, fill_len, drain_raddr;
  logic          drain_active;
  logic [7:0]    rx_byte;

  assign wr_ictl  = wr_i && addr_i == OFS_ICTL;
  assign rd_ictl  = rd_i && addr_i == OFS_ICTL;
  assign soft_rst = wr_ictl && !wdata_i[0] && !wdata_i[1] && wdata_i[31];
  assign tx_take  = wr_i && addr_i == OFS_TXDAT && !drain_active && tx_cnt_q != '0;
  assign tx_send  = tx_take && (tx_wr_q + CW'(1) == tx_cnt_q);
  assign rx_pop   = rd_i && addr_i == OFS_RXDAT && rx_cnt_q != '0;
  assign rx_open  = !busy_q && rx_cnt_q < CW'(FRAME_MAX);

  frame_rx_fill #(.FRAME_MAX(FRAME_MAX), .CW(CW)) u_fill (
    .clk_i, .rst_ni,
    .soft_clr_i(soft_rst),
    .open_i    (rx_open),
    .rx_valid_i, .rx_last_i,
    .rx_ready_o,
    .store_o   (fill_store),
    .waddr_o   (fill_waddr),
    .start_o   (fill_start),
    .done_o    (fill_done),
    .len_o     (fill_len)
  );

  frame_byte_ram #(.DEPTH(FRAME_MAX), .AW(CW)) u_rx_ram (
    .clk_i,
    .we_i   (fill_store && !soft_rst),
    .waddr_i(fill_waddr),
    .wdata_i(rx_data_i),
    .raddr_i(rx_rd_q),
    .rdata_o(rx_byte)
  );

  frame_byte_ram #(.DEPTH(FRAME_MAX), .AW(CW)) u_tx_ram (
    .clk_i,
    .we_i   (tx_take),
    .waddr_i(tx_wr_q),
    .wdata_i(wdata_i[7:0]),
    .raddr_i(drain_raddr),
    .rdata_o(tx_data_o)
  );

  frame_tx_drain #(.CW(CW)) u_drain (
    .clk_i, .rst_ni,
    .soft_clr_i(soft_rst),
    .start_i   (tx_send),
    .len_i     (tx_cnt_q),
    .tx_ready_i,
    .active_o  (drain_active),
    .raddr_o   (drain_raddr),
    .tx_valid_o, .tx_last_o
  );

  always_comb begin
    busy_d   = busy_q;
    rx_cnt_d = rx_cnt_q;
    rx_rd_d  = rx_rd_q;
    tx_cnt_d = tx_cnt_q;
    tx_wr_d  = tx_wr_q;
    ictl_d   = ictl_q;

    if (rd_ictl) ictl_d.test = 1'b0;
    if (rx_pop) begin
      rx_cnt_d = rx_cnt_q - CW'(1);
      rx_rd_d  = rx_rd_q + CW'(1);
    end
    if (wr_i && addr_i == OFS_TXCNT) begin
      tx_cnt_d = (wdata_i <= 32'(FRAME_MAX)) ? wdata_i[CW-1:0] : '0;
      tx_wr_d  = '0;
    end
    if (wr_ictl) begin
      if (wdata_i[0])      ictl_d.tx_done = 1'b0;
      else if (wdata_i[1]) ictl_d.rx_done = 1'b0;
      busy_d = |ictl_d;
    end
    if (tx_take) begin
      tx_wr_d = tx_wr_q + CW'(1);
      if (tx_send) begin
        tx_cnt_d       = '0;
        tx_wr_d        = '0;
        ictl_d.tx_done = 1'b1;
        busy_d         = 1'b1;
      end
    end
    if (fill_start) busy_d = 1'b1;
    if (fill_done) begin
      rx_cnt_d       = fill_len;
      rx_rd_d        = '0;
      ictl_d.rx_done = 1'b1;
      busy_d         = 1'b1;
    end
    // soft reset: wipe everything, leave only the test flag
    if (soft_rst) begin
      busy_d   = 1'b1;
      rx_cnt_d = '0;
      rx_rd_d  = '0;
      tx_cnt_d = '0;
      tx_wr_d  = '0;
      ictl_d   = '{test: 1'b1, rx_done: 1'b0, tx_done: 1'b0};
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_ID0:   rdata_d = ID_WORD0;
      OFS_ID1:   rdata_d = ID_WORD1;
      OFS_BUSY:  rdata_d = {31'b0, busy_q};
      OFS_RXCNT: rdata_d = 32'(rx_cnt_q);
      OFS_TXCNT: rdata_d = 32'(tx_cnt_q);
      OFS_ICTL:  rdata_d = ictl_word(ictl_q);
      OFS_RXDAT: rdata_d = rx_pop ? {24'b0, rx_byte} : 32'b0;
      default:   rdata_d = 32'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b1;
      rx_cnt_q <= '0;
      rx_rd_q  <= '0;
      tx_cnt_q <= '0;
      tx_wr_q  <= '0;
      ictl_q   <= '0;
      rdata_q  <= '0;
    end else begin
      busy_q   <= busy_d;
      rx_cnt_q <= rx_cnt_d;
      rx_rd_q  <= rx_rd_d;
      tx_cnt_q <= tx_cnt_d;
      tx_wr_q  <= tx_wr_d;
      ictl_q   <= ictl_d;
      if (rd_i) rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |ictl_q;

  a_r9_start_closes_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_start && !soft_rst) |=> busy_q);

  a_r10_done_posts_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_done && !soft_rst) |=> ictl_q.rx_done && rx_cnt_q == $past(fill_len));

  a_r7_send_posts_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_send |=> ictl_q.tx_done && busy_q && tx_cnt_q == '0 && tx_valid_o);

  a_r5_test_clears_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ictl && !wr_ictl) |=> !ictl_q.test);

  a_r6_tx_cnt_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt_q <= CW'(FRAME_MAX));

  a_r10_rx_cnt_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt_q <= CW'(FRAME_MAX));
endmodule

// File: tb/frame_port_bench.sv
module frame_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_MAX  = 1514;
  localparam int NVEC       = 13;

  // {offset, expected value right after reset}
  localparam logic [37:0] VEC [0:NVEC-1] = '{
    {6'h00, 32'h4D49_5053}, {6'h04, 32'h4E45_5430}, {6'h08, 32'd1},
    {6'h0C, 32'd0}, {6'h10, 32'd0}, {6'h14, 32'd0}, {6'h18, 32'd0},
    {6'h1C, 32'd0}, {6'h20, 32'd0}, {6'h24, 32'd0}, {6'h2C, 32'd0},
    {6'h30, 32'd0}, {6'h3C, 32'd0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  logic        rx_valid_i = 1'b0, rx_last_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_ready_o;
  logic        tx_valid_o, tx_last_o;
  logic [7:0]  tx_data_o;
  logic        tx_ready_i = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_port #(.FRAME_MAX(FRAME_MAX)) u_frame_port (
    .clk_i(clk), .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o, .irq_o,
    .rx_valid_i, .rx_data_i, .rx_last_i, .rx_ready_o,
    .tx_valid_o, .tx_data_o, .tx_last_o, .tx_ready_i
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic rx_push(input logic [7:0] d, input logic l);
    rx_valid_i = 1'b1; rx_data_i = d; rx_last_i = l;
    while (!rx_ready_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 reset outputs
    chk("R2 irq after reset", 32'(irq_o), 32'd0);
    chk("R2 rx_ready after reset", 32'(rx_ready_o), 32'd0);
    chk("R2 tx_valid after reset", 32'(tx_valid_o), 32'd0);

    // R1 R2 register sweep
    for (int i = 0; i < NVEC; i++) begin
      bus_rd(VEC[i][37:32], v);
      chk($sformatf("R1/R2 sweep ofs 0x%02h", VEC[i][37:32]), v, VEC[i][31:0]);
    end

    // R12 read-only writes ignored
    bus_wr(6'h08, 32'd0);
    bus_wr(6'h00, 32'h1234_5678);
    bus_wr(6'h0C, 32'd99);
    bus_rd(6'h08, v); chk("R12 busy unchanged", v, 32'd1);
    bus_rd(6'h00, v); chk("R12 id unchanged", v, 32'h4D49_5053);
    bus_rd(6'h0C, v); chk("R12 rx count unchanged", v, 32'd0);

    // R4 zero write with no flags opens the gate
    bus_wr(6'h14, 32'd0);
    bus_rd(6'h08, v); chk("R4 busy after zero ack", v, 32'd0);
    chk("R9 rx_ready open", 32'(rx_ready_o), 32'd1);

    // R9 R10 short frame
    rx_push(8'h10, 1'b0); rx_push(8'h21, 1'b0); rx_push(8'h32, 1'b0); rx_push(8'h43, 1'b1);
    rx_valid_i = 1'b0; rx_last_i = 1'b0;
    chk("R9 rx_ready closed after frame", 32'(rx_ready_o), 32'd0);
    chk("R3 irq after rx", 32'(irq_o), 32'd1);
    bus_rd(6'h0C, v); chk("R10 rx count", v, 32'd4);
    bus_rd(6'h08, v); chk("R9 busy after rx", v, 32'd1);
    bus_rd(6'h14, v); chk("R10 rx done flag", v, 32'd2);
    bus_rd(6'h1C, v); chk("R11 byte0", v, 32'h10);
    bus_rd(6'h1C, v); chk("R11 byte1", v, 32'h21);
    bus_rd(6'h0C, v); chk("R11 count after 2 pops", v, 32'd2);
    bus_rd(6'h1C, v); chk("R11 byte2", v, 32'h32);
    bus_rd(6'h1C, v); chk("R11 byte3", v, 32'h43);
    bus_rd(6'h1C, v); chk("R11 empty read", v, 32'd0);
    bus_rd(6'h0C, v); chk("R11 count stays 0", v, 32'd0);

    // R9 frame offered while busy is held off
    rx_valid_i = 1'b1; rx_data_i = 8'hEE; rx_last_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 ready low while busy", 32'(rx_ready_o), 32'd0);
    rx_valid_i = 1'b0; rx_last_i = 1'b0;
    bus_rd(6'h0C, v); chk("R9 nothing stored while busy", v, 32'd0);

    // R7 R8 transmit with stall
    bus_wr(6'h10, 32'd3);
    bus_rd(6'h10, v); chk("R6 tx count stored", v, 32'd3);
    bus_wr(6'h20, 32'hFFFF_FFA1); bus_wr(6'h20, 32'hB2); bus_wr(6'h20, 32'hC3);
    chk("R7 tx_valid after send", 32'(tx_valid_o), 32'd1);
    chk("R8 first byte", 32'(tx_data_o), 32'hA1);
    @(negedge clk); @(negedge clk);
    chk("R8 held under stall", 32'(tx_data_o), 32'hA1);
    chk("R8 not last under stall", 32'(tx_last_o), 32'd0);
    bus_rd(6'h10, v); chk("R7 tx count back to 0", v, 32'd0);
    bus_rd(6'h14, v); chk("R7 tx done set", v, 32'd3);
    bus_wr(6'h10, 32'd2);
    bus_wr(6'h20, 32'h55); // ignored: drain in progress
    tx_ready_i = 1'b1;
    chk("R8 byte0", 32'(tx_data_o), 32'hA1);
    @(negedge clk);
    chk("R8 byte1", 32'(tx_data_o), 32'hB2);
    @(negedge clk);
    chk("R8 byte2", 32'(tx_data_o), 32'hC3);
    chk("R8 last flag", 32'(tx_last_o), 32'd1);
    @(negedge clk);
    chk("R8 stream ends", 32'(tx_valid_o), 32'd0);
    bus_wr(6'h20, 32'h11); bus_wr(6'h20, 32'h22);
    chk("R7 write during drain ignored b0", 32'(tx_data_o), 32'h11);
    chk("R8 second frame valid", 32'(tx_valid_o), 32'd1);
    @(negedge clk);
    chk("R7 write during drain ignored b1", 32'(tx_data_o), 32'h22);
    chk("R8 second frame last", 32'(tx_last_o), 32'd1);
    @(negedge clk);

    // R4 priority
    bus_wr(6'h14, 32'd3);
    bus_rd(6'h14, v); chk("R4 bit0 wins", v, 32'd2);
    bus_rd(6'h08, v); chk("R4 busy with flag left", v, 32'd1);
    bus_wr(6'h14, 32'h8000_0002);
    bus_rd(6'h14, v); chk("R4 bit1 beats bit31", v, 32'd0);
    bus_rd(6'h08, v); chk("R4 busy cleared", v, 32'd0);
    chk("R3 irq low", 32'(irq_o), 32'd0);

    // R6 R7 count limits
    bus_wr(6'h10, 32'd2000);
    bus_rd(6'h10, v); chk("R6 oversize count", v, 32'd0);
    bus_wr(6'h20, 32'h99);
    bus_rd(6'h14, v); chk("R7 zero count write ignored", v, 32'd0);
    bus_wr(6'h10, 32'd1514);
    bus_rd(6'h10, v); chk("R6 max count", v, 32'd1514);

    // R4 R5 soft reset
    bus_wr(6'h14, 32'h8000_0000);
    chk("R3 irq on test flag", 32'(irq_o), 32'd1);
    bus_rd(6'h10, v); chk("R4 soft reset clears tx count", v, 32'd0);
    bus_rd(6'h08, v); chk("R4 busy after soft reset", v, 32'd1);
    bus_rd(6'h14, v); chk("R5 read returns test", v, 32'h8000_0000);
    bus_rd(6'h14, v); chk("R5 test cleared", v, 32'd0);
    chk("R5 irq drops", 32'(irq_o), 32'd0);
    bus_wr(6'h14, 32'd0);
    bus_rd(6'h08, v); chk("R4 zero write reopens", v, 32'd0);

    // R10 oversize frame truncated
    for (int i = 0; i < FRAME_MAX + 6; i++) rx_push(i[7:0], i == FRAME_MAX + 5);
    rx_valid_i = 1'b0; rx_last_i = 1'b0;
    bus_rd(6'h0C, v); chk("R10 truncated count", v, 32'(FRAME_MAX));
    bus_wr(6'h14, 32'd2);
    bus_rd(6'h08, v); chk("R4 busy after rx ack", v, 32'd0);
    chk("R9 gate shut at full count", 32'(rx_ready_o), 32'd0);
    bus_rd(6'h1C, v); chk("R10 first stored byte", v, 32'h00);
    bus_rd(6'h1C, v); chk("R10 second stored byte", v, 32'h01);
    bus_rd(6'h0C, v); chk("R11 count after pops", v, 32'(FRAME_MAX - 2));
    chk("R9 gate reopens below full", 32'(rx_ready_o), 32'd1);

    done = 1'b1;
    report();
    $finish;
  end
endmodule